// File: doc/BRIEF.md
# Tempo-Selectable Square-Wave Tune Player

This block plays a fixed sixteen-step tune as a square wave on one output pin, meant to drive an external low-pass filter and amplifier. Each step of the tune is either a pitched note or a rest. A pitch counter runs at the system clock rate. For every note it is reloaded with the system clock rate divided by twice the note frequency, and each time it runs out the speaker pin flips.

A duration counter sets how long each step lasts. When it expires, the step index moves on to the next entry of the tune and goes back to the first entry after the last one. Software selects one of four tempo codes through a single-word write port. The code scales the length of every step, and a new code is applied only when the next step starts. A second output holds the external amplifier enabled at all times.

Top module: `tone_sequencer`

## Requirements
- R1: While `rst_n` is low, `speaker` is low. After `rst_n` rises, the internal reset clears on the second rising edge, and the first step of the tune starts updating on the third rising edge, using tempo code 0.
- R2: `amp_en` is high in every cycle, including during reset.
- R3: During a pitched step with reload value P = CLK_HZ / (2 * f), using integer division, `speaker` is low in the first cycle of the step and inverts after every P cycles of that step.
- R4: During a rest step (f = 0), `speaker` stays low for the whole step.
- R5: Step i lasts B(i) * (BEAT_CYCLES >> code) cycles, where B(i) is 2 for steps 10 and 14 and 1 for every other step. A higher code therefore gives a faster tempo.
- R6: A write with `tempo_wr_en` high stores `tempo_wr_data[1:0]` as the tempo code. Bits 31 to 2 of the data word have no effect.
- R7: A captured tempo code applies only to steps that start after the edge that captured it. The step already playing keeps its length, and this holds even when the write lands on that step's final edge.
- R8: Steps play in index order 0, 1, ..., 15, and step 0 follows step 15.
- R9: The tune, as frequencies in Hz for steps 0 to 15, is 262, 294, 330, 262, 262, 294, 330, 262, 330, 349, 392, 0, 330, 349, 392, 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (100 MHz by default) |
| rst_n | input | 1 | Asynchronous active-low reset |
| tempo_wr_en | input | 1 | Write strobe for the tempo word |
| tempo_wr_data | input | 32 | Tempo word; only the low two bits are used |
| speaker | output | 1 | Square-wave audio output |
| amp_en | output | 1 | Amplifier enable, always high |

## Verification
The player is first run through the whole tune at the slowest tempo. This separates wrong pitch periods and wrong step lengths from errors in ordering and wrap-around. Directed writes then land in the middle of a step and on the final edge of a step, which shows whether a code change is deferred correctly or cuts the current step short. Data words with the upper bits set and all four codes tried in turn tell ignored bits apart from the decoded ones. Random writes at random spacing, followed by a reset in mid-tune, mix the tempo changes with rests, long steps and partial half-periods.

// File: rtl/tone_pkg.sv
package tone_pkg;

  localparam int unsigned TUNE_LEN    = 16;
  localparam int unsigned IDX_W       = $clog2(TUNE_LEN);
  localparam int unsigned LOWEST_HZ   = 262;
  localparam int unsigned TEMPO_W     = 2;
  localparam int unsigned TEMPO_CODES = 1 << TEMPO_W;

  typedef logic [IDX_W-1:0]   note_idx_t;
  typedef logic [TEMPO_W-1:0] tempo_code_t;

  // Pitch of each tune step in Hz; zero marks a rest (R9)
  function automatic int unsigned tune_hz(input note_idx_t idx);
    int unsigned hz;
    case (idx)
      4'd0, 4'd3, 4'd4, 4'd7:  hz = 262;
      4'd1, 4'd5:              hz = 294;
      4'd2, 4'd6, 4'd8, 4'd12: hz = 330;
      4'd9, 4'd13:             hz = 349;
      4'd10, 4'd14:            hz = 392;
      default:                 hz = 0;
    endcase
    return hz;
  endfunction

  // Steps that last two beat units (R5)
  function automatic logic tune_long(input note_idx_t idx);
    return (idx == 4'd10) || (idx == 4'd14);
  endfunction

  function automatic int unsigned half_reload(input int unsigned clk_hz, input note_idx_t idx);
    int unsigned hz;
    hz = tune_hz(idx);
    if (hz == 0) return 0;
    return clk_hz / (2 * hz);
  endfunction

endpackage

// File: rtl/tone_rst_sync.sv
module tone_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_out = sync_q[1];

endmodule

// File: rtl/tone_tempo_store.sv
module tone_tempo_store
  import tone_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output tempo_code_t       code
);

  tempo_code_t code_q;
  tempo_code_t code_d;
  logic        unused_hi_bits;

  assign unused_hi_bits = ^wr_data[DATA_W-1:TEMPO_W];

  always_comb begin
    code_d = code_q;
    if (wr_en) begin
      code_d = wr_data[TEMPO_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
    end else begin
      code_q <= code_d;
    end
  end

  assign code = code_q;

  AST_TEMPO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(code_q)); // R6

endmodule

// File: rtl/tone_note_stepper.sv
module tone_note_stepper
  import tone_pkg::*;
#(
  parameter int unsigned BEAT_CYCLES = 25_000_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  tempo_code_t tempo_code,
  output note_idx_t   note_idx,
  output note_idx_t   next_idx,
  output logic        note_end
);

  localparam int unsigned MAX_LEN   = 2 * BEAT_CYCLES;
  localparam int unsigned DUR_W     = $clog2(MAX_LEN + 1);
  localparam int unsigned FIRST_LEN = (tune_long('0) ? 2 : 1) * BEAT_CYCLES;

  logic [DUR_W-1:0] unit_len [TEMPO_CODES];
  logic [DUR_W-1:0] dur_q, dur_d;
  logic [DUR_W-1:0] load_len;
  note_idx_t        idx_q, idx_d;

  // One beat unit per tempo code, halving with each higher code
  for (genvar c = 0; c < TEMPO_CODES; c++) begin : g_unit
    assign unit_len[c] = DUR_W'(BEAT_CYCLES >> c);
  end

  assign note_end = (dur_q == '0);
  assign next_idx = (idx_q == note_idx_t'(TUNE_LEN - 1)) ? '0 : idx_q + 1'b1;
  assign load_len = tune_long(next_idx) ? (unit_len[tempo_code] << 1) : unit_len[tempo_code];

  always_comb begin
    dur_d = dur_q;
    idx_d = idx_q;
    if (note_end) begin
      dur_d = load_len - DUR_W'(1);
      idx_d = next_idx;
    end else begin
      dur_d = dur_q - DUR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dur_q <= DUR_W'(FIRST_LEN - 1);
      idx_q <= '0;
    end else begin
      dur_q <= dur_d;
      idx_q <= idx_d;
    end
  end

  assign note_idx = idx_q;

  AST_NOTE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (note_end && idx_q == note_idx_t'(TUNE_LEN - 1)) |=> (idx_q == '0)); // R8

  AST_NOTE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (note_end && idx_q != note_idx_t'(TUNE_LEN - 1)) |=> (idx_q == note_idx_t'($past(idx_q) + 1'b1))); // R8

  AST_NOTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !note_end |=> $stable(idx_q)); // R5

  AST_DUR_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    dur_q < DUR_W'(MAX_LEN)); // R5

endmodule

// File: rtl/tone_pitch_gen.sv
module tone_pitch_gen
  import tone_pkg::*;
#(
  parameter int unsigned CLK_HZ = 100_000_000
) (
  input  logic      clk,
  input  logic      rst_n,
  input  note_idx_t note_idx,
  input  note_idx_t next_idx,
  input  logic      note_end,
  output logic      speaker
);

  localparam int unsigned HALF_W     = $clog2(CLK_HZ / (2 * LOWEST_HZ) + 1);
  localparam int unsigned FIRST_RELD = half_reload(CLK_HZ, '0);
  localparam int unsigned FIRST_HALF = (FIRST_RELD == 0) ? 0 : FIRST_RELD - 1;

  logic [HALF_W-1:0] reload_tab [TUNE_LEN];
  logic [HALF_W-1:0] cur_reload, nxt_reload;
  logic [HALF_W-1:0] half_q, half_d;
  logic              spk_q, spk_d;

  // Half-period reload per step, computed from the clock rate
  for (genvar n = 0; n < TUNE_LEN; n++) begin : g_reload
    assign reload_tab[n] = HALF_W'(half_reload(CLK_HZ, note_idx_t'(n)));
  end

  assign cur_reload = reload_tab[note_idx];
  assign nxt_reload = reload_tab[next_idx];

  always_comb begin
    half_d = half_q;
    spk_d  = spk_q;
    if (note_end) begin
      spk_d  = 1'b0;
      half_d = (nxt_reload == '0) ? '0 : nxt_reload - HALF_W'(1);
    end else if (cur_reload == '0) begin
      spk_d  = 1'b0;
      half_d = '0;
    end else if (half_q == '0) begin
      spk_d  = ~spk_q;
      half_d = cur_reload - HALF_W'(1);
    end else begin
      half_d = half_q - HALF_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= HALF_W'(FIRST_HALF);
      spk_q  <= 1'b0;
    end else begin
      half_q <= half_d;
      spk_q  <= spk_d;
    end
  end

  assign speaker = spk_q;

  AST_REST_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_reload == '0) |-> !speaker); // R4

  AST_EDGE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (speaker != $past(speaker)) |-> $past(half_q == '0 || note_end)); // R3

  AST_STEP_STARTS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    note_end |=> !speaker); // R3

  AST_HALF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_reload == '0) ? (half_q == '0) : (half_q < cur_reload)); // R3

endmodule

// File: rtl/tone_sequencer.sv
module tone_sequencer
  import tone_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 100_000_000,
  parameter int unsigned BEAT_CYCLES = 25_000_000,
  parameter int unsigned DATA_W      = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tempo_wr_en,
  input  logic [DATA_W-1:0] tempo_wr_data,
  output logic              speaker,
  output logic              amp_en
);

  logic        core_rst_n;
  tempo_code_t tempo_code;
  note_idx_t   note_idx;
  note_idx_t   next_idx;
  logic        note_end;

  tone_rst_sync u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (core_rst_n)
  );

  tone_tempo_store #(.DATA_W(DATA_W)) u_tempo (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .wr_en   (tempo_wr_en),
    .wr_data (tempo_wr_data),
    .code    (tempo_code)
  );

  tone_note_stepper #(.BEAT_CYCLES(BEAT_CYCLES)) u_stepper (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .tempo_code (tempo_code),
    .note_idx   (note_idx),
    .next_idx   (next_idx),
    .note_end   (note_end)
  );

  tone_pitch_gen #(.CLK_HZ(CLK_HZ)) u_pitch (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .note_idx (note_idx),
    .next_idx (next_idx),
    .note_end (note_end),
    .speaker  (speaker)
  );

  assign amp_en = 1'b1;

  AST_RESET_QUIET: assert property (@(posedge clk)
    !core_rst_n |-> !speaker); // R1

endmodule

// File: tb/tone_sequencer_test.sv
module tone_sequencer_test;

  localparam int unsigned CLK_HZ = 8000;
  localparam int unsigned BEAT   = 64;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tempo_wr_en;
  logic [31:0] tempo_wr_data;
  logic        speaker;
  logic        amp_en;

  int n_checks = 0;
  int n_fails  = 0;
  bit checking = 1'b0;
  bit done     = 1'b0;
  string phase = "R1";

  always #10 clk = ~clk;

  tone_sequencer #(.CLK_HZ(CLK_HZ), .BEAT_CYCLES(BEAT), .DATA_W(32)) uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .tempo_wr_en   (tempo_wr_en),
    .tempo_wr_data (tempo_wr_data),
    .speaker       (speaker),
    .amp_en        (amp_en)
  );

  // Tune per R9, step lengths per R5
  function automatic int hz_of(input int i);
    case (i)
      0, 3, 4, 7:   return 262;
      1, 5:         return 294;
      2, 6, 8, 12:  return 330;
      9, 13:        return 349;
      10, 14:       return 392;
      default:      return 0;
    endcase
  endfunction

  function automatic int beats_of(input int i);
    return (i == 10 || i == 14) ? 2 : 1;
  endfunction

  function automatic int reload_of(input int i);
    int f;
    f = hz_of(i);
    return (f == 0) ? 0 : CLK_HZ / (2 * f);
  endfunction

  // Expected-behaviour model built from R1 to R9
  int m_idx, m_dur, m_half, m_tempo, m_rel;
  bit m_spk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rel   = 0;
      m_idx   = 0;
      m_tempo = 0;
      m_dur   = beats_of(0) * BEAT - 1;
      m_half  = reload_of(0) - 1;
      m_spk   = 1'b0;
    end else if (m_rel < 2) begin
      m_rel = m_rel + 1;
    end else begin
      int nidx;
      bit wr_now;
      int wr_code;
      wr_now  = tempo_wr_en;
      wr_code = int'(tempo_wr_data[1:0]);
      if (m_dur == 0) begin
        nidx   = (m_idx + 1) % 16;
        m_idx  = nidx;
        m_dur  = beats_of(nidx) * (BEAT >> m_tempo) - 1;
        m_spk  = 1'b0;
        m_half = (reload_of(nidx) == 0) ? 0 : reload_of(nidx) - 1;
      end else begin
        m_dur = m_dur - 1;
        if (reload_of(m_idx) == 0) begin
          m_spk  = 1'b0;
          m_half = 0;
        end else if (m_half == 0) begin
          m_spk  = ~m_spk;
          m_half = reload_of(m_idx) - 1;
        end else begin
          m_half = m_half - 1;
        end
      end
      if (wr_now) m_tempo = wr_code;
    end
  end

  always @(negedge clk) begin
    if (checking && !done) begin
      string tag;
      if (!rst_n || m_rel < 2)        tag = "R1";
      else if (reload_of(m_idx) == 0) tag = "R4";
      else                            tag = "R3";
      n_checks++;
      if (speaker !== m_spk) begin
        n_fails++;
        $display("FAIL %s (phase %s) speaker actual=%0b expected=%0b step=%0d", tag, phase, speaker, m_spk, m_idx);
      end
      n_checks++;
      if (amp_en !== 1'b1) begin
        n_fails++;
        $display("FAIL R2 (phase %s) amp_en actual=%0b expected=1", phase, amp_en);
      end
    end
  end

  task automatic report();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  endtask

  task automatic run(input int cycles);
    repeat (cycles) @(negedge clk);
  endtask

  task automatic write_tempo(input logic [31:0] word);
    tempo_wr_en   = 1'b1;
    tempo_wr_data = word;
    @(negedge clk);
    tempo_wr_en   = 1'b0;
    tempo_wr_data = $urandom;
  endtask

  initial begin
    int unsigned seed_dummy;
    seed_dummy    = $urandom(32'd4021);
    rst_n         = 1'b0;
    tempo_wr_en   = 1'b0;
    tempo_wr_data = '0;
    checking      = 1'b1;
    phase = "R1";
    run(5);
    rst_n = 1'b1;
    run(40);
    // Whole tune plus wrap at the slowest tempo
    phase = "R8";
    run(1400);
    // Mid-step write must not shorten the step in progress
    phase = "R7";
    run(17);
    write_tempo(32'd3);
    run(600);
    // Write on the final edge of a step
    while (m_dur != 0) @(negedge clk);
    write_tempo(32'd1);
    run(400);
    // Upper data bits are ignored
    phase = "R6";
    write_tempo(32'hFFFF_FFFE);
    run(500);
    write_tempo(32'h8000_0000);
    run(300);
    // Every tempo code in turn
    phase = "R5";
    for (int c = 0; c < 4; c++) begin
      write_tempo(32'(c));
      run(400);
    end
    // Random tempo words at random spacing
    phase = "R3";
    for (int k = 0; k < 40; k++) begin
      write_tempo($urandom);
      run($urandom_range(1, 150));
    end
    // Reset in the middle of the tune
    phase = "R1";
    rst_n = 1'b0;
    run(3);
    rst_n = 1'b1;
    run(120);
    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog (phase %s) actual=timeout expected=completion", phase);
      report();
    end
  end

endmodule